// File: doc/BRIEF.md
# Ticket-Based Hardware Semaphore

This block is a single-owner hardware lock that sits behind a small synchronous register port. Any number of requesters share the port. Each one first reads a ticket register, which hands out a new nonzero number on every read. The requester then tries to take the lock by writing that number into the lock register. It reads the lock register back, and it holds the lock only if the value it reads equals its own ticket. Any other value means another requester got there first, and it has to try again later.

The lock register accepts a write only while it is free (reads zero). A competitor's later write therefore cannot overwrite the ticket that is already stored. The holder frees the lock by writing zero. The port uses a read strobe, a write strobe, a byte offset and 32-bit write data. Read data comes back registered, one cycle after the read strobe, and it holds its value until the next read.

Top module: `ticket_lock_top`

## Requirements
- R1: After reset the read data output is zero, the lock register reads zero (free), and the first read of the ticket register returns 1.
- R2: A read at offset 0x8 (ticket register) returns the current ticket, and the ticket then advances by one for the next read.
- R3: The ticket never takes the value zero. After the all-ones value of the ticket width, the next read returns 1.
- R4: A write of a nonzero value at offset 0xC (lock register) while the lock reads zero stores the full 32-bit value, and the stored value is visible to the next read.
- R5: A write of a nonzero value at offset 0xC while the lock holds a nonzero value is ignored, and the stored value stays unchanged.
- R6: A write of zero at offset 0xC frees the lock, so it reads zero afterwards. A write of zero to a lock that is already free leaves it at zero.
- R7: Writes at offset 0x8 are ignored, and the ticket sequence continues unchanged.
- R8: Reads at any offset other than 0x8 and 0xC return zero. Only reads at 0x8 advance the ticket.
- R9: Read data updates only in the cycle after a read strobe, and it holds its value while no read is issued.
- R10: When a read and a write hit the lock register in the same cycle, the read returns the value stored before the write, and the write takes effect for later reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_off | input | ADDR_W | Byte offset of the access |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Registered read data |

## Verification
The bench builds the block with a 3-bit ticket (CNT_W = 3), so the ticket runs through 1 to 7 and wraps back to 1 after a handful of reads. This puts the wrap past zero in R3 within reach of a short directed sequence. The data path stays at its full 32 bits, so the wide value stored in the lock register under R4 still covers bits far above the ticket width. The sequence walks through one contention round: a claim, a rejected competitor, a release, and a simultaneous read and write.

// File: rtl/ticket_lock_pkg.sv
package ticket_lock_pkg;

  // Which register a read access selects.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_TKT  = 2'd1,
    SEL_LOCK = 2'd2
  } rd_sel_e;

  // Outcome of a lock-register write.
  typedef enum logic [1:0] {
    LK_IDLE    = 2'd0,
    LK_CLAIM   = 2'd1,
    LK_RELEASE = 2'd2,
    LK_REJECT  = 2'd3
  } lock_op_e;

endpackage

// File: rtl/tl_rst_sync.sv
// Asynchronous assertion, synchronous release of the active-low reset.
module tl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/tl_reg_decode.sv
// Offset decode: turns strobes and offset into per-register enables.
module tl_reg_decode
  import ticket_lock_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFF_TKT  = 'h08,
  parameter logic [ADDR_W-1:0] OFF_LOCK = 'h0C
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] off,
  output logic              tkt_take,
  output logic              lock_wr,
  output rd_sel_e           rd_sel
);

  logic hit_tkt;
  logic hit_lock;

  always_comb begin
    hit_tkt  = (off == OFF_TKT);
    hit_lock = (off == OFF_LOCK);
    tkt_take = rd & hit_tkt;
    lock_wr  = wr & hit_lock;
    if (hit_tkt) begin
      rd_sel = SEL_TKT;
    end else if (hit_lock) begin
      rd_sel = SEL_LOCK;
    end else begin
      rd_sel = SEL_NONE;
    end
  end

endmodule

// File: rtl/tl_ticket_gen.sv
// Ticket source: starts at one, advances on every take, never yields zero.
module tl_ticket_gen #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic [CNT_W-1:0] tkt_q
);

  localparam logic [CNT_W-1:0] TKT_FIRST = CNT_W'(1);
  localparam logic [CNT_W-1:0] TKT_LAST  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] tkt_d;
  logic             tkt_en;

  always_comb begin
    tkt_en = take;
    if (tkt_q == TKT_LAST) begin
      tkt_d = TKT_FIRST;
    end else begin
      tkt_d = tkt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tkt_q <= TKT_FIRST;
    end else if (tkt_en) begin
      tkt_q <= tkt_d;
    end
  end

endmodule

// File: rtl/tl_hold_reg.sv
// Lock state: claims only when free with a nonzero value, frees on zero.
module tl_hold_reg
  import ticket_lock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lock_q
);

  logic              is_free;
  logic              wd_zero;
  lock_op_e          op;
  logic              lock_en;
  logic [DATA_W-1:0] lock_d;

  always_comb begin
    is_free = (lock_q == '0);
    wd_zero = (wdata == '0);
    if (!wr_en) begin
      op = LK_IDLE;
    end else if (wd_zero) begin
      op = LK_RELEASE;
    end else if (is_free) begin
      op = LK_CLAIM;
    end else begin
      op = LK_REJECT;
    end

    lock_en = 1'b0;
    lock_d  = lock_q;
    case (op)
      LK_CLAIM: begin
        lock_en = 1'b1;
        lock_d  = wdata;
      end
      LK_RELEASE: begin
        lock_en = 1'b1;
        lock_d  = '0;
      end
      default: begin
        lock_en = 1'b0;
        lock_d  = lock_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

endmodule

// File: rtl/ticket_lock_top.sv
module ticket_lock_top
  import ticket_lock_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter int                CNT_W     = 32,
  parameter int                RST_STAGE = 2,
  parameter logic [ADDR_W-1:0] OFF_TKT   = 'h08,
  parameter logic [ADDR_W-1:0] OFF_LOCK  = 'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int PAD_W = DATA_W - CNT_W;

  logic              rst_s_n;
  logic              tkt_take;
  logic              lock_wr;
  rd_sel_e           rd_sel;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] cnt_ext;
  logic [DATA_W-1:0] sem_q;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rdata_en;

  tl_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  tl_reg_decode #(
    .ADDR_W   (ADDR_W),
    .OFF_TKT  (OFF_TKT),
    .OFF_LOCK (OFF_LOCK)
  ) u_dec (
    .rd       (req_rd),
    .wr       (req_wr),
    .off      (req_off),
    .tkt_take (tkt_take),
    .lock_wr  (lock_wr),
    .rd_sel   (rd_sel)
  );

  tl_ticket_gen #(.CNT_W(CNT_W)) u_tkt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .take  (tkt_take),
    .tkt_q (cnt_q)
  );

  tl_hold_reg #(.DATA_W(DATA_W)) u_lock (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_en  (lock_wr),
    .wdata  (req_wdata),
    .lock_q (sem_q)
  );

  // Zero-extend the ticket onto the data bus.
  generate
    if (PAD_W > 0) begin : g_pad
      assign cnt_ext = {{PAD_W{1'b0}}, cnt_q};
    end else begin : g_nopad
      assign cnt_ext = cnt_q;
    end
  endgenerate

  // Read mux and registered read data, loaded only on a read strobe.
  always_comb begin
    rdata_en = req_rd;
    case (rd_sel)
      SEL_TKT:  rdata_d = cnt_ext;
      SEL_LOCK: rdata_d = sem_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/ticket_lock_chk.sv
module ticket_lock_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter int                CNT_W    = 32,
  parameter logic [ADDR_W-1:0] OFF_TKT  = 'h08,
  parameter logic [ADDR_W-1:0] OFF_LOCK = 'h0C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd,
  input logic              wr,
  input logic [ADDR_W-1:0] off,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] sem
);

  // R3: ticket never zero
  p_tkt_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);

  // R2: a ticket read moves the ticket on (by one unless wrapping)
  p_tkt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && off == OFF_TKT && cnt != {CNT_W{1'b1}}) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R8: ticket frozen without a ticket read (covers R7 writes too)
  p_tkt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && off == OFF_TKT) |=> $stable(cnt));

  // R4: claim of a free lock stores the write value
  p_lock_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == OFF_LOCK && sem == '0) |=> (sem == $past(wdata)));

  // R5: nonzero write to a held lock changes nothing
  p_lock_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == OFF_LOCK && sem != '0 && wdata != '0) |=> $stable(sem));

  // R6: zero write frees the lock
  p_lock_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == OFF_LOCK && wdata == '0) |=> (sem == '0));

  // R9: read data steady without a read strobe
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  // R10: lock read returns the value held before a same-cycle write
  p_rd_old_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && off == OFF_LOCK) |=> (rdata == $past(sem)));

endmodule

bind ticket_lock_top ticket_lock_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CNT_W    (CNT_W),
  .OFF_TKT  (OFF_TKT),
  .OFF_LOCK (OFF_LOCK)
) u_chk (
  .clk   (clk),
  .rst_n (rst_s_n),
  .rd    (req_rd),
  .wr    (req_wr),
  .off   (req_off),
  .wdata (req_wdata),
  .rdata (rsp_rdata),
  .cnt   (cnt_q),
  .sem   (sem_q)
);

// File: tb/ticket_lock_top_test.sv
module ticket_lock_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int T_CNT_W    = 3;
  localparam int T_CNT_MAX  = (1 << T_CNT_W) - 1;

  logic        clk;
  logic        rst_n;
  logic        req_rd;
  logic        req_wr;
  logic [7:0]  req_off;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;

  int    n_chk;
  int    n_fail;
  bit    model_on;
  bit    done;

  // Behavioural reference state
  int unsigned m_cnt;
  logic [31:0] m_sem;
  logic [31:0] m_rdata;

  ticket_lock_top #(.CNT_W(T_CNT_W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_rd    (req_rd),
    .req_wr    (req_wr),
    .req_off   (req_off),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model, updated at each rising edge from the driven inputs.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt   <= 1;
      m_sem   <= '0;
      m_rdata <= '0;
    end else if (model_on) begin
      if (req_rd) begin
        if (req_off == 8'h08)      m_rdata <= 32'(m_cnt);
        else if (req_off == 8'h0C) m_rdata <= m_sem;
        else                       m_rdata <= '0;
        if (req_off == 8'h08) m_cnt <= (m_cnt == T_CNT_MAX) ? 1 : m_cnt + 1;
      end
      if (req_wr && req_off == 8'h0C) begin
        if (req_wdata == '0)   m_sem <= '0;
        else if (m_sem == '0)  m_sem <= req_wdata;
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (model_on && !done) check(rsp_rdata, m_rdata, "R9 model");
  end

  task automatic rd_chk(input logic [7:0] off, input logic [31:0] exp, input string tag);
    req_rd  = 1'b1;
    req_off = off;
    @(negedge clk);
    req_rd  = 1'b0;
    check(rsp_rdata, exp, tag);
  endtask

  task automatic wr_do(input logic [7:0] off, input logic [31:0] data);
    req_wr    = 1'b1;
    req_off   = off;
    req_wdata = data;
    @(negedge clk);
    req_wr    = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; model_on = 1'b0; done = 1'b0;
    rst_n = 1'b0; req_rd = 1'b0; req_wr = 1'b0; req_off = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;

    check(rsp_rdata, 32'h0, "R1 rdata after reset");
    rd_chk(8'h0C, 32'h0, "R1 lock free");
    rd_chk(8'h08, 32'h1, "R1 first ticket");
    rd_chk(8'h08, 32'h2, "R2 ticket advances");

    wr_do(8'h0C, 32'h2);
    rd_chk(8'h0C, 32'h2, "R4 claim free lock");
    wr_do(8'h0C, 32'h5);
    rd_chk(8'h0C, 32'h2, "R5 competitor ignored");

    rd_chk(8'h08, 32'h3, "R8 lock reads do not advance ticket");
    wr_do(8'h08, 32'h55);
    rd_chk(8'h08, 32'h4, "R7 ticket write ignored");
    rd_chk(8'h00, 32'h0, "R8 unmapped 0x00");
    rd_chk(8'h10, 32'h0, "R8 unmapped 0x10");
    rd_chk(8'h08, 32'h5, "R8 unmapped reads keep ticket");

    wr_do(8'h0C, 32'h0);
    rd_chk(8'h0C, 32'h0, "R6 release");
    wr_do(8'h0C, 32'h0);
    rd_chk(8'h0C, 32'h0, "R6 zero write to free lock");

    rd_chk(8'h08, 32'h6, "R2 ticket 6");
    rd_chk(8'h08, 32'h7, "R3 ticket at top");
    rd_chk(8'h08, 32'h1, "R3 wrap skips zero");
    rd_chk(8'h08, 32'h2, "R3 after wrap");

    wr_do(8'h0C, 32'hA5A5_0003);
    rd_chk(8'h0C, 32'hA5A5_0003, "R4 full width claim");
    repeat (3) @(negedge clk);
    check(rsp_rdata, 32'hA5A5_0003, "R9 hold without read");

    wr_do(8'h0C, 32'h0);
    req_rd = 1'b1; req_wr = 1'b1; req_off = 8'h0C; req_wdata = 32'h6;
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    check(rsp_rdata, 32'h0, "R10 read sees old value");
    rd_chk(8'h0C, 32'h6, "R10 write took effect");
    wr_do(8'h0C, 32'h0);
    rd_chk(8'h0C, 32'h0, "R6 final release");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule